// File: doc/BRIEF.md
# Bridge Interrupt Controller

This block gathers error and status events raised by the transaction engines of a bus bridge and turns them into interrupt requests. Each event arrives as a one-cycle pulse on its own input line and sets a sticky status bit. Software clears a bit by writing a one to it. Two layers of enabling decide whether a latched event raises an interrupt: a mask with one bit per source, then a single device-wide enable.

The block drives two interrupt outputs. The first is an active-high registered request toward a local interrupt controller. The second is an active-low line toward the peripheral bus interface core. It combines the bridge interrupt with an asynchronous, active-high request from user logic, so either source pulls the line low. A small synchronous register port reads and writes the status, mask and device-enable registers.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: After reset, the status, mask and device-enable registers read zero, `irq_local` is low and `periph_irq_n` is high while `user_irq_req` is low.
- R2: A one on bit i of `evt_pulse` sets status bit i. The bit stays set after the pulse ends. The source bit positions are: 0 master-read SERR, 1 master-read PERR, 2 master-read target abort, 3 master-write SERR, 4 master-write PERR, 5 master-write target abort, 6 master-write master abort, 7 burst-write retry, 8 burst-write retry-disconnect, 9 burst-write retry timeout, 10 initiator read/write SERR.
- R3: A write to the status register (address 0) clears each status bit whose write-data bit is one. Bits written with zero are unchanged.
- R4: If an event pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register (address 1, one bit per source at the same positions as R2) and the device-enable register (address 2, bit 0) read back the values written. A read started with `reg_rd_en` returns the register value from before that clock edge on `reg_rdata` one cycle later, and `reg_rdata` holds until the next read.
- R6: `irq_local` equals the OR over all sources of (status AND mask), ANDed with the device enable, as sampled at the previous clock edge. It has one cycle of latency.
- R7: A source whose mask bit is zero still latches its status bit but does not raise `irq_local`.
- R8: While the device enable is zero, `irq_local` stays low whatever the status and mask hold.
- R9: `periph_irq_n` is low whenever `user_irq_req` is high or `irq_local` is high. The user path passes through no clock and no enable.
- R10: With `user_irq_req` held low, `periph_irq_n` is exactly the inverse of `irq_local`.
- R11: A read of any other address (3) returns zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| user_irq_req | input | 1 | Asynchronous active-high user interrupt request |
| irq_local | output | 1 | Active-high interrupt to the local controller |
| periph_irq_n | output | 1 | Active-low interrupt to the peripheral bus core |

## Verification
The bench targets a clear and an event that land on the same bit in the same cycle. A design where the clear wins would lose an error that was never seen. It checks that masked sources still latch, so a design that gates the set with the mask would hide the history of an event. It toggles the device enable while status is pending, which catches a missing global gate or an extra cycle of latency. It raises the user request between clock edges, which exposes a design that registers or gates that path.

// File: rtl/bic_pkg.sv
package bic_pkg;
   localparam int unsigned BIC_NUM_SRC_DEF = 11;

   // register addresses
   localparam int unsigned BIC_ADDR_STATUS = 0;
   localparam int unsigned BIC_ADDR_MASK   = 1;
   localparam int unsigned BIC_ADDR_GEN    = 2;

   // source bit positions
   typedef enum int unsigned {
      SRC_MRD_SERR     = 0,
      SRC_MRD_PERR     = 1,
      SRC_MRD_TABORT   = 2,
      SRC_MWR_SERR     = 3,
      SRC_MWR_PERR     = 4,
      SRC_MWR_TABORT   = 5,
      SRC_MWR_MABORT   = 6,
      SRC_BWR_RETRY    = 7,
      SRC_BWR_RETRY_DC = 8,
      SRC_BWR_RETRY_TO = 9,
      SRC_INIT_SERR    = 10
   } bic_src_e;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_GEN    = 2'd2,
      SEL_NONE   = 2'd3
   } bic_sel_e;
endpackage

// File: rtl/bic_status_bank.sv
module bic_status_bank #(
   parameter int unsigned NUM_SRC = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] status_o
);
   // one sticky cell per source; set has priority over clear
   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_cell
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (set_i[gi])
            bit_q <= 1'b1;
         else if (clr_i[gi])
            bit_q <= 1'b0;
      end
      assign status_o[gi] = bit_q;
   end
endmodule

// File: rtl/bic_reg_port.sv
module bic_reg_port
   import bic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 11,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] status_i,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic               gen_o,
   output logic [DATA_W-1:0]  rdata_o
);
   bic_sel_e             sel;
   logic [NUM_SRC-1:0]   mask_q;
   logic                 gen_q;
   logic [DATA_W-1:0]    rd_mux;
   logic [DATA_W-1:0]    rdata_q;

   always_comb begin
      if (addr_i == ADDR_W'(BIC_ADDR_STATUS))
         sel = SEL_STATUS;
      else if (addr_i == ADDR_W'(BIC_ADDR_MASK))
         sel = SEL_MASK;
      else if (addr_i == ADDR_W'(BIC_ADDR_GEN))
         sel = SEL_GEN;
      else
         sel = SEL_NONE;
   end

   assign clr_o = (wr_en_i && sel == SEL_STATUS) ? wdata_i[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         gen_q  <= 1'b0;
      end else if (wr_en_i) begin
         if (sel == SEL_MASK) mask_q <= wdata_i[NUM_SRC-1:0];
         if (sel == SEL_GEN)  gen_q  <= wdata_i[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_STATUS: rd_mux[NUM_SRC-1:0] = status_i;
         SEL_MASK:   rd_mux[NUM_SRC-1:0] = mask_q;
         SEL_GEN:    rd_mux[0]           = gen_q;
         default:    rd_mux              = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en_i)
         rdata_q <= rd_mux;
   end

   assign mask_o  = mask_q;
   assign gen_o   = gen_q;
   assign rdata_o = rdata_q;
endmodule

// File: rtl/bic_irq_merge.sv
module bic_irq_merge #(
   parameter int unsigned NUM_SRC          = 11,
   parameter int unsigned USER_SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               gen_i,
   input  logic               user_req_i,
   output logic               user_eff_o,
   output logic               irq_o,
   output logic               periph_n_o
);
   logic irq_q;
   logic bridge_n;

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= gen_i & (|(status_i & mask_i));
   end

   // user request path: direct by default, optional synchronizer chain
   if (USER_SYNC_STAGES == 0) begin : g_user_async
      assign user_eff_o = user_req_i;
   end else begin : g_user_sync
      logic [USER_SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            sync_q <= '0;
         else
            sync_q <= {sync_q[USER_SYNC_STAGES-2 >= 0 ? USER_SYNC_STAGES-2 : 0 : 0], user_req_i};
      end
      assign user_eff_o = sync_q[USER_SYNC_STAGES-1];
   end

   assign bridge_n   = ~irq_q;
   assign irq_o      = irq_q;
   assign periph_n_o = (~user_eff_o) & bridge_n;
endmodule

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl
   import bic_pkg::*;
#(
   parameter int unsigned NUM_SRC          = BIC_NUM_SRC_DEF,
   parameter int unsigned ADDR_W           = 2,
   parameter int unsigned DATA_W           = 32,
   parameter int unsigned USER_SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_pulse,
   input  logic               reg_wr_en,
   input  logic               reg_rd_en,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               user_irq_req,
   output logic               irq_local,
   output logic               periph_irq_n
);
   localparam int unsigned NUM_REGS = 3;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("bridge_irq_ctrl: NUM_SRC must lie in 1..DATA_W");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("bridge_irq_ctrl: ADDR_W too small for the register map");
   end
   if (USER_SYNC_STAGES == 1) begin : g_bad_sync
      $error("bridge_irq_ctrl: USER_SYNC_STAGES must be 0 or at least 2");
   end

   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] en_q;
   logic               gen_q;
   logic               user_eff;

   bic_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (evt_pulse),
      .clr_i    (clr_vec),
      .status_o (status_q)
   );

   bic_reg_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (reg_wr_en),
      .rd_en_i  (reg_rd_en),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .status_i (status_q),
      .clr_o    (clr_vec),
      .mask_o   (en_q),
      .gen_o    (gen_q),
      .rdata_o  (reg_rdata)
   );

   bic_irq_merge #(.NUM_SRC(NUM_SRC), .USER_SYNC_STAGES(USER_SYNC_STAGES)) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .status_i   (status_q),
      .mask_i     (en_q),
      .gen_i      (gen_q),
      .user_req_i (user_irq_req),
      .user_eff_o (user_eff),
      .irq_o      (irq_local),
      .periph_n_o (periph_irq_n)
   );
endmodule

// File: rtl/bridge_irq_ctrl_chk.sv
module bridge_irq_ctrl_chk #(
   parameter int unsigned NUM_SRC = 11,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_pulse,
   input logic               reg_wr_en,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_SRC-1:0] status,
   input logic [NUM_SRC-1:0] enable,
   input logic               gen,
   input logic               user_eff,
   input logic               irq_local,
   input logic               periph_irq_n
);
   // R2 / R4: every pulsed source is set after the edge, clear or not
   p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((status & $past(evt_pulse)) == $past(evt_pulse)));

   // R3: written-one bits without a coincident event are cleared
   p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == '0) |=>
      ((status & $past(reg_wdata[NUM_SRC-1:0]) & ~$past(evt_pulse)) == '0));

   // R7: with an all-zero mask no interrupt follows
   p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable == '0) |=> !irq_local);

   // R8: device enable low blocks the interrupt
   p_global_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gen |=> !irq_local);

   // R6: a pending enabled source with device enable raises the interrupt
   p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gen && ((status & enable) != '0)) |=> irq_local);

   // R9: the user request alone pulls the peripheral line low
   p_user_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      user_eff |-> !periph_irq_n);

   // R9: the bridge interrupt alone pulls the peripheral line low
   p_bridge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_local |-> !periph_irq_n);
endmodule

bind bridge_irq_ctrl bridge_irq_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .evt_pulse    (evt_pulse),
   .reg_wr_en    (reg_wr_en),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .status       (status_q),
   .enable       (en_q),
   .gen          (gen_q),
   .user_eff     (user_eff),
   .irq_local    (irq_local),
   .periph_irq_n (periph_irq_n)
);

// File: tb/bridge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_irq_ctrl_tb_top;
   localparam int unsigned NS = 11;
   localparam int unsigned AW = 2;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] evt_pulse = '0;
   logic          reg_wr_en = 1'b0;
   logic          reg_rd_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          user_irq_req = 1'b0;
   logic          irq_local;
   logic          periph_irq_n;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // bench model
   logic [NS-1:0] m_status = '0;
   logic [NS-1:0] m_mask = '0;
   logic          m_gen = 1'b0;
   logic          m_irq = 1'b0;
   logic [DW-1:0] m_rdata = '0;

   always #2.5 clk = ~clk;

   bridge_irq_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .user_irq_req(user_irq_req), .irq_local(irq_local),
      .periph_irq_n(periph_irq_n));

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      logic [DW-1:0] v;
      v = '0;
      case (a)
         2'd0: v[NS-1:0] = m_status;
         2'd1: v[NS-1:0] = m_mask;
         2'd2: v[0]      = m_gen;
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic logic model_pn(input logic irq, input logic usr);
      return !(irq || usr);
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare at next negedge
   task automatic step(input logic [NS-1:0] ev, input logic wr, input logic rd,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd, input string req);
      logic [NS-1:0] clr;
      logic [NS-1:0] n_status;
      logic [NS-1:0] n_mask;
      logic          n_gen;
      logic          n_irq;
      evt_pulse = ev; reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = wd;
      clr = (wr && a == 2'd0) ? wd[NS-1:0] : '0;
      n_status = (m_status & ~clr) | ev;
      n_mask = (wr && a == 2'd1) ? wd[NS-1:0] : m_mask;
      n_gen  = (wr && a == 2'd2) ? wd[0] : m_gen;
      n_irq  = m_gen & (|(m_status & m_mask));
      if (rd) m_rdata = model_read(a);
      @(posedge clk);
      @(negedge clk);
      m_status = n_status; m_mask = n_mask; m_gen = n_gen; m_irq = n_irq;
      evt_pulse = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
      check({req, " R6 irq_local"}, DW'(irq_local), DW'(m_irq));
      check({req, " R9 periph_irq_n"}, DW'(periph_irq_n), DW'(model_pn(m_irq, user_irq_req)));
      if (rd) check({req, " R5 reg_rdata"}, reg_rdata, m_rdata);
   endtask

   task automatic rd_reg(input logic [AW-1:0] a, input string req);
      step('0, 1'b0, 1'b1, a, '0, req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_1A2B));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq_local", DW'(irq_local), '0);
      check("R1 periph_irq_n", DW'(periph_irq_n), 1);
      rd_reg(2'd0, "R1 status");
      rd_reg(2'd1, "R1 mask");
      rd_reg(2'd2, "R1 gen");

      // R2 sticky set, source 10 (initiator SERR), mask still off (R7)
      step(NS'(1) << 10, 1'b0, 1'b0, '0, '0, "R2 set");
      step('0, 1'b0, 1'b0, '0, '0, "R7 masked latch");
      rd_reg(2'd0, "R2 sticky");

      // R5 mask write, R8 gen still zero
      step('0, 1'b1, 1'b0, 2'd1, 32'h0000_0400, "R5 mask wr");
      step('0, 1'b0, 1'b0, '0, '0, "R8 gen off");
      step('0, 1'b0, 1'b0, '0, '0, "R8 gen off");
      rd_reg(2'd1, "R5 mask rb");
      // enable device -> irq after one cycle (R6)
      step('0, 1'b1, 1'b0, 2'd2, 32'h1, "R6 gen on");
      step('0, 1'b0, 1'b0, '0, '0, "R6 irq up");
      step('0, 1'b0, 1'b0, '0, '0, "R6 irq held");
      rd_reg(2'd2, "R5 gen rb");

      // R4 set wins over clear on the same bit
      step(NS'(1) << 10, 1'b1, 1'b0, 2'd0, 32'h0000_0400, "R4 set vs clr");
      rd_reg(2'd0, "R4 survives");
      // R3 clear with bit mask, other bits kept
      step(NS'(1) << 3, 1'b0, 1'b0, '0, '0, "R2 src3");
      step('0, 1'b1, 1'b0, 2'd0, 32'h0000_0400, "R3 clr10");
      rd_reg(2'd0, "R3 src3 kept");
      step('0, 1'b0, 1'b0, '0, '0, "R3 irq drop");

      // R11 unmapped address
      step('0, 1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF, "R11 wr ign");
      rd_reg(2'd3, "R11 rd zero");
      rd_reg(2'd1, "R11 mask kept");
      rd_reg(2'd2, "R11 gen kept");

      // R9 / R10 user request between edges
      user_irq_req = 1'b1; #1;
      check("R9 user low", DW'(periph_irq_n), 0);
      user_irq_req = 1'b0; #1;
      check("R10 user off", DW'(periph_irq_n), DW'(!irq_local));
      step('0, 1'b0, 1'b0, '0, '0, "R10 idle");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [NS-1:0] ev;
         logic wr, rd;
         logic [AW-1:0] a;
         logic [DW-1:0] wd;
         ev = '0;
         if ($urandom_range(0, 3) == 0) ev = NS'($urandom) & NS'($urandom) & NS'($urandom);
         wr = ($urandom_range(0, 3) == 0);
         rd = ($urandom_range(0, 2) == 0);
         a  = AW'($urandom_range(0, 3));
         wd = $urandom;
         if ($urandom_range(0, 15) == 0) user_irq_req = ~user_irq_req;
         step(ev, wr, rd, a, wd, "R2 R3 R4 R6 rand");
      end
      user_irq_req = 1'b0;
      step('0, 1'b0, 1'b0, '0, '0, "R10 end");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule